// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block holds the configuration registers of a multi-function peripheral controller. A host reaches them through two byte-wide addresses: a pointer port that chooses a register and a value port that reads or writes the chosen register. Out of reset the block is closed. While closed, the host cannot alter or see any register. To open it, the host writes the entry byte 0x87 to the pointer port twice in a row. Writing 0xAA to the pointer port closes it again.

While the block is open, pointer 0x07 selects one of `NDEV` logical devices. Each device has a small set of registers: an enable flag, two 16-bit base addresses, an interrupt number and an interrupt type. The block drives all of these continuously to the peripherals on output buses. Pointers 0x20 to 0x2F reach sixteen shared registers that have no bank. Bit 6 of the shared register at 0x26 opens access to the per-device registers.

Top module: `idxcfg_port`

## Requirements
- R1: After reset the block is closed. The value port, every device output and `cfg_open` read 0.
- R2: While closed, value-port writes are ignored and the value port reads 0x00. The block opens (`cfg_open`=1) after two consecutive pointer-port writes of 0x87.
- R3: After the first 0x87, any other write cancels the entry. This covers a pointer write of another byte and any value-port write. Two fresh 0x87 writes are then needed.
- R4: While open, a pointer write of 0xAA closes the block. Later value writes have no effect, and the values already stored are kept.
- R5: Pointer 0x07 holds the logical device number, which reads back through the value port. The number selects the bank that pointers 0x30 and above reach.
- R6: In a device bank, slot 0x30 bit 0 drives that device's bit of `dev_active`. Only bit 0 is stored, and the slot reads back with bits 7:1 at 0.
- R7: Slots 0x60 and 0x61 are the high and low bytes of `dev_base0`. Slots 0x62 and 0x63 are the high and low bytes of `dev_base1`.
- R8: Slot 0x70 drives `dev_irq_num` and slot 0x71 drives `dev_irq_type` (0x02 means active-high, edge-triggered).
- R9: Pointers 0x20 to 0x2F are shared registers, readable and writable whatever the device number. While bit 6 of register 0x26 is 0, per-device writes are ignored and per-device reads give 0x00.
- R10: Unimplemented slots, and device numbers of `NDEV` or more, read 0x00 and ignore writes.
- R11: A write takes effect at the clock edge on which it is presented. The value port shows the register at the current pointer with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_sel | input | 1 | 0 selects the pointer port, 1 selects the value port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Value-port read data |
| cfg_open | output | 1 | High while configuration access is open |
| dev_active | output | NDEV | Per-device enable flags |
| dev_base0 | output | NDEV*16 | First base address per device, device d at [d*16 +: 16] |
| dev_base1 | output | NDEV*16 | Second base address per device |
| dev_irq_num | output | NDEV*8 | Interrupt number per device, device d at [d*8 +: 8] |
| dev_irq_type | output | NDEV*8 | Interrupt type per device |

## Verification
Every write is registered on the edge at which it is presented. `cfg_open`, the device outputs and `bus_rdata` therefore all show the result one edge after the write, with `bus_rdata` following the pointer combinationally. The reference model applies each write at the same edge. The bench compares every output on the falling edge after that edge, so each result is checked in the first cycle it is due. The bench holds the bus idle for several cycles after reset, which covers the two-cycle reset release.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} cfg_state_e;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] PTR_LDN   = 8'h07;
  localparam logic [7:0] PTR_GATE  = 8'h26;
  localparam int         GATE_BIT  = 6;
  localparam logic [7:0] SLOT_ACT  = 8'h30;
  localparam logic [7:0] SLOT_B0H  = 8'h60;
  localparam logic [7:0] SLOT_B0L  = 8'h61;
  localparam logic [7:0] SLOT_B1H  = 8'h62;
  localparam logic [7:0] SLOT_B1L  = 8'h63;
  localparam logic [7:0] SLOT_IRQN = 8'h70;
  localparam logic [7:0] SLOT_IRQT = 8'h71;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic       open_o
);
  cfg_state_e state_q, state_d;
  logic ptr_wr;
  assign ptr_wr = wr && !sel;

  always_comb begin
    state_d = state_q;
    if (wr) begin
      case (state_q)
        ST_LOCKED: if (ptr_wr && wdata == KEY_ENTER) state_d = ST_KEY1;
        ST_KEY1:   state_d = (ptr_wr && wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   if (ptr_wr && wdata == KEY_EXIT) state_d = ST_LOCKED;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == ST_OPEN);

  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_o) |-> $past(ptr_wr && wdata == KEY_ENTER));
  a_r3_cancel_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_KEY1 && wr && !(ptr_wr && wdata == KEY_ENTER)) |=> !open_o);
  a_r4_exit_key: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && ptr_wr && wdata == KEY_EXIT) |=> !open_o);
endmodule

// File: rtl/cfgp_dev_bank.sv
module cfgp_dev_bank
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [7:0]  slot,
  input  logic [7:0]  wdata,
  output logic        act_o,
  output logic [15:0] base0_o,
  output logic [15:0] base1_o,
  output logic [7:0]  irqn_o,
  output logic [7:0]  irqt_o,
  output logic [7:0]  rdata_o
);
  logic        act_q, act_d;
  logic [7:0]  b0h_q, b0l_q, b1h_q, b1l_q, irqn_q, irqt_q;
  logic [7:0]  b0h_d, b0l_d, b1h_d, b1l_d, irqn_d, irqt_d;

  always_comb begin
    act_d = act_q; b0h_d = b0h_q; b0l_d = b0l_q; b1h_d = b1h_q;
    b1l_d = b1l_q; irqn_d = irqn_q; irqt_d = irqt_q;
    if (we) begin
      case (slot)
        SLOT_ACT:  act_d  = wdata[0];
        SLOT_B0H:  b0h_d  = wdata;
        SLOT_B0L:  b0l_d  = wdata;
        SLOT_B1H:  b1h_d  = wdata;
        SLOT_B1L:  b1l_d  = wdata;
        SLOT_IRQN: irqn_d = wdata;
        SLOT_IRQT: irqt_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; b0h_q <= '0; b0l_q <= '0; b1h_q <= '0;
      b1l_q <= '0; irqn_q <= '0; irqt_q <= '0;
    end else begin
      act_q <= act_d; b0h_q <= b0h_d; b0l_q <= b0l_d; b1h_q <= b1h_d;
      b1l_q <= b1l_d; irqn_q <= irqn_d; irqt_q <= irqt_d;
    end
  end

  always_comb begin
    case (slot)
      SLOT_ACT:  rdata_o = {7'd0, act_q};
      SLOT_B0H:  rdata_o = b0h_q;
      SLOT_B0L:  rdata_o = b0l_q;
      SLOT_B1H:  rdata_o = b1h_q;
      SLOT_B1L:  rdata_o = b1l_q;
      SLOT_IRQN: rdata_o = irqn_q;
      SLOT_IRQT: rdata_o = irqt_q;
      default:   rdata_o = 8'h00;
    endcase
  end

  assign act_o   = act_q;
  assign base0_o = {b0h_q, b0l_q};
  assign base1_o = {b1h_q, b1l_q};
  assign irqn_o  = irqn_q;
  assign irqt_o  = irqt_q;

  a_r6_act_only_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (we && slot == SLOT_ACT) |=> (rdata_o[7:1] == 7'd0 || slot != SLOT_ACT));
endmodule

// File: rtl/idxcfg_port.sv
module idxcfg_port
  import cfgp_pkg::*;
#(
  parameter int NDEV = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              cfg_open,
  output logic [NDEV-1:0]   dev_active,
  output logic [NDEV*16-1:0] dev_base0,
  output logic [NDEV*16-1:0] dev_base1,
  output logic [NDEV*8-1:0] dev_irq_num,
  output logic [NDEV*8-1:0] dev_irq_type
);
  localparam int NGLOB = 16;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic open_w;
  cfgp_key_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .wr(bus_wr), .sel(bus_sel),
    .wdata(bus_wdata), .open_o(open_w)
  );

  logic [7:0] ptr_q, ptr_d, ldn_q, ldn_d;
  logic [7:0] glob_q [NGLOB];
  logic       ptr_we, val_we, glob_we, gate, ldn_ok, dev_space;

  assign ptr_we    = open_w && bus_wr && !bus_sel && bus_wdata != KEY_EXIT;
  assign val_we    = open_w && bus_wr && bus_sel;
  assign glob_we   = val_we && ptr_q[7:4] == 4'h2;
  assign gate      = glob_q[PTR_GATE[3:0]][GATE_BIT];
  assign ldn_ok    = ldn_q < 8'(NDEV);
  assign dev_space = ptr_q >= SLOT_ACT;

  always_comb begin
    ptr_d = ptr_q;
    ldn_d = ldn_q;
    if (ptr_we) ptr_d = bus_wdata;
    if (val_we && ptr_q == PTR_LDN) ldn_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ptr_q <= '0;
      ldn_q <= '0;
      for (int i = 0; i < NGLOB; i++) glob_q[i] <= '0;
    end else begin
      ptr_q <= ptr_d;
      ldn_q <= ldn_d;
      if (glob_we) glob_q[ptr_q[3:0]] <= bus_wdata;
    end
  end

  logic [7:0] bank_rd [NDEV];
  for (genvar d = 0; d < NDEV; d++) begin : g_bank
    logic bank_we;
    assign bank_we = val_we && gate && dev_space && ldn_q == 8'(d);
    cfgp_dev_bank u_bank (
      .clk(clk), .rst_n(rst_i_n), .we(bank_we), .slot(ptr_q), .wdata(bus_wdata),
      .act_o(dev_active[d]), .base0_o(dev_base0[d*16 +: 16]),
      .base1_o(dev_base1[d*16 +: 16]), .irqn_o(dev_irq_num[d*8 +: 8]),
      .irqt_o(dev_irq_type[d*8 +: 8]), .rdata_o(bank_rd[d])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (open_w) begin
      if (ptr_q == PTR_LDN)          bus_rdata = ldn_q;
      else if (ptr_q[7:4] == 4'h2)   bus_rdata = glob_q[ptr_q[3:0]];
      else if (dev_space && gate && ldn_ok) begin
        for (int i = 0; i < NDEV; i++)
          if (ldn_q == 8'(i)) bus_rdata = bank_rd[i];
      end
    end
  end

  assign cfg_open = open_w;

  a_r2_closed_reads_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |-> bus_rdata == 8'h00);
  a_r4_closed_keeps_state: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_open |=> ($stable(dev_base0) && $stable(dev_active) && $stable(dev_irq_num)));
  a_r9_gate_blocks_dev: assert property (@(posedge clk) disable iff (!rst_i_n)
    !gate |=> ($stable(dev_base1) && $stable(dev_irq_type) && $stable(dev_active)));
  a_r10_bad_ldn_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cfg_open && !ldn_ok && dev_space) |-> bus_rdata == 8'h00);
endmodule

// File: tb/idxcfg_port_bench.sv
module idxcfg_port_bench;
  localparam int NDEV = 9;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_sel = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic cfg_open;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*16-1:0] dev_base0, dev_base1;
  logic [NDEV*8-1:0] dev_irq_num, dev_irq_type;

  idxcfg_port #(.NDEV(NDEV)) u_idxcfg_port (.*);

  always #5 clk = ~clk;

  int nvec = 0, nbad = 0;
  string cur_req = "R1";
  int m_state = 0, m_ptr = 0, m_ldn = 0;
  int m_glob [16];
  int m_dev [NDEV][256];

  function automatic bit impl(int s);
    return s == 'h30 || (s >= 'h60 && s <= 'h63) || s == 'h70 || s == 'h71;
  endfunction

  function automatic int m_read();
    if (m_state != 2) return 0;
    if (m_ptr == 7) return m_ldn;
    if (m_ptr >= 'h20 && m_ptr <= 'h2F) return m_glob[m_ptr - 'h20];
    if (m_ptr >= 'h30 && m_glob[6][6] && m_ldn < NDEV) return m_dev[m_ldn][m_ptr];
    return 0;
  endfunction

  task automatic m_apply(bit sel, int d);
    case (m_state)
      0: if (!sel && d == 'h87) m_state = 1;
      1: m_state = (!sel && d == 'h87) ? 2 : 0;
      default: begin
        if (!sel) begin
          if (d == 'hAA) m_state = 0; else m_ptr = d;
        end else if (m_ptr == 7) m_ldn = d;
        else if (m_ptr >= 'h20 && m_ptr <= 'h2F) m_glob[m_ptr - 'h20] = d;
        else if (m_ptr >= 'h30 && m_glob[6][6] && m_ldn < NDEV && impl(m_ptr))
          m_dev[m_ldn][m_ptr] = (m_ptr == 'h30) ? (d & 1) : d;
      end
    endcase
  endtask

  task automatic chk(string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rdata", int'(bus_rdata), m_read());
    chk("open", int'(cfg_open), m_state == 2 ? 1 : 0);
    for (int d = 0; d < NDEV; d++) begin
      chk("active", int'(dev_active[d]), m_dev[d]['h30]);
      chk("base0", int'(dev_base0[d*16 +: 16]), m_dev[d]['h60] * 256 + m_dev[d]['h61]);
      chk("base1", int'(dev_base1[d*16 +: 16]), m_dev[d]['h62] * 256 + m_dev[d]['h63]);
      chk("irqn", int'(dev_irq_num[d*8 +: 8]), m_dev[d]['h70]);
      chk("irqt", int'(dev_irq_type[d*8 +: 8]), m_dev[d]['h71]);
    end
  endtask

  task automatic cyc(bit wr, bit sel, int d);
    bus_wr = wr; bus_sel = sel; bus_wdata = 8'(d);
    @(posedge clk);
    if (wr && rst_n) m_apply(sel, d);
    @(negedge clk);
    bus_wr = 0;
    compare_all();
  endtask

  task automatic pw(int d); cyc(1, 0, d); endtask
  task automatic vw(int d); cyc(1, 1, d); endtask
  task automatic wreg(int p, int d); pw(p); vw(d); endtask

  initial begin
    for (int i = 0; i < 16; i++) m_glob[i] = 0;
    for (int d = 0; d < NDEV; d++) for (int s = 0; s < 256; s++) m_dev[d][s] = 0;
    @(negedge clk);
    cur_req = "R1";
    repeat (2) cyc(0, 0, 0);
    rst_n = 1;
    repeat (4) cyc(0, 0, 0);

    cur_req = "R2";
    vw('h55); pw('h60); vw('h12); pw('h87); vw('h33);
    pw('h87); pw('h87);
    pw(7); cyc(0, 0, 0);

    cur_req = "R3";
    pw('hAA); pw('h87); pw('h55); pw('h87); vw(1); pw('h87); pw('h87);

    cur_req = "R9";
    wreg(7, 1); wreg('h60, 'h12); pw('h60); cyc(0, 0, 0);
    wreg('h26, 'h40); wreg('h2A, 'hC1); wreg(7, 3); pw('h2A); cyc(0, 0, 0);
    wreg('h2F, 'h5A);

    cur_req = "R5";
    for (int d = 0; d < NDEV; d++) begin
      wreg(7, d); pw(7);
      cur_req = "R6"; wreg('h30, (d % 2) ? 'hFF : 'hFE);
      cur_req = "R7";
      wreg('h60, 'h10 + d); wreg('h61, 'h80 + d); wreg('h62, 'h03); wreg('h63, 'h88 - d);
      cur_req = "R8"; wreg('h70, d + 1); wreg('h71, 'h02);
      cur_req = "R5";
    end
    for (int d = 0; d < NDEV; d++) begin
      wreg(7, d); pw('h61); pw('h30); pw('h70);
    end

    cur_req = "R10";
    wreg(7, 2); wreg('h50, 'h77); wreg('hF0, 'hEE); pw('h71);
    wreg(7, 9); wreg('h60, 'h99); pw('h60); wreg(7, 'hFF); pw('h30);

    cur_req = "R9";
    wreg(7, 4); wreg('h26, 'h00); wreg(7, 4); wreg('h61, 'h00); pw('h61);
    wreg('h26, 'h40); pw('h61);

    cur_req = "R4";
    pw('hAA); vw('h00); pw('h61); vw('h00); pw('h87); vw('h11);
    pw('h87); pw('h87); pw('h61); wreg(7, 5); pw('h60);

    cur_req = "R11";
    wreg('h71, 'h03); wreg('h30, 'h00); pw(7); vw(6); pw('h70);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL %s watchdog: actual hung expected done", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule